// File: doc/BRIEF.md
# Dual-Device SDRAM Command Sequencer

This block turns single-cycle command requests into the control-pin patterns of a synchronous DRAM bus that serves one or two devices. The two devices share the row strobe, column strobe, write enable, multiplexed address, bank and byte-mask lines. Each device has its own active-low chip select and its own clock enable. A requester presents a command code, a two-bit device mask, bank, address or mode word, an auto-precharge flag and a byte mask. The block places the matching pattern on the pins for one clock and pulses a done flag. When both mask bits are set, the command reaches the two devices in the same cycle.

Clock enable separates auto-refresh from self-refresh. The auto-precharge flag is placed on the address line that selects between the addressed bank and all banks for precharge, and between plain and auto-precharging bursts for read and write. Reads and writes are refused until an external initialization flag is set. Leaving self-refresh raises clock enable again and makes the block busy for a programmable number of cycles.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is asserted and after it is released, both chip selects and all three strobes are high, both clock enables are high, address, bank and byte mask are zero, `cmd_done` and `cmd_reject` are low and `req_ready` is high.
- R2: In every cycle that carries no command, the strobes are high and the address, bank and byte mask are zero. With the default `IDLE_NOP` of 0, both chip selects are high (deselect).
- R3: A request that is accepted at a clock edge (`req_valid` and `req_ready` high) drives its pattern from that edge for exactly one cycle. `cmd_done` is high in that same cycle, and the pins return to idle at the next edge unless a new request was accepted.
- R4: Code 0 (activate) drives row strobe low, column strobe high and write enable high, with `req_addr` on the address lines and `req_bank` on the bank lines.
- R5: Code 1 (read) drives row strobe high, column strobe low and write enable high. Code 2 (write) drives row strobe high, column strobe low and write enable low. Both drive `req_addr` with bit 10 replaced by `req_auto`, put `req_bank` on the bank lines and `req_dqm` on the byte mask.
- R6: Code 3 (precharge) drives row strobe low, column strobe high and write enable low. Address bit 10 equals `req_auto` and all other address bits are zero. The bank lines carry `req_bank` when `req_auto` is 0 and zero when it is 1 (all banks).
- R7: Codes 4 (auto-refresh) and 5 (self-refresh entry) both drive row strobe low, column strobe low and write enable high. Code 4 leaves clock enable high. Code 5 drives the clock enable of each selected device low in the same cycle, and it stays low afterwards.
- R8: Code 7 (load mode) drives row strobe, column strobe and write enable all low, with the mode word `req_addr` on the address lines and `req_bank` on the bank lines.
- R9: Bit i of `req_dev` selects device i. For every issued command, `sd_cs_n[i]` is low exactly when bit i is set, so mask 3 asserts both chip selects together.
- R10: A read or write request that arrives while `init_done` is low, or any request with device mask 0, is refused. The pins stay idle, `cmd_done` stays low, and `cmd_reject` is high for one cycle at the same time a command would have appeared. All other commands are accepted regardless of `init_done`.
- R11: Code 6 (self-refresh exit) raises the clock enable of each selected device in the cycle after acceptance, with idle strobes and `cmd_done` high. `req_ready` is then low for `EXIT_CYC` cycles, and requests presented in that time have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, same as the memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_done | input | 1 | Initialization finished; enables read and write |
| req_valid | input | 1 | Request present |
| req_cmd | input | 3 | Command code (see requirements) |
| req_dev | input | 2 | Device mask, bit i selects device i |
| req_bank | input | 2 | Bank number |
| req_addr | input | 13 | Row, column or mode word |
| req_auto | input | 1 | Auto-precharge / all-bank flag |
| req_dqm | input | 2 | Byte mask for read and write |
| req_ready | output | 1 | Block can accept a request |
| cmd_done | output | 1 | A command was issued this cycle |
| cmd_reject | output | 1 | A request was refused |
| sd_cs_n | output | 2 | Per-device chip select, active low |
| sd_cke | output | 2 | Per-device clock enable |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 13 | Address lines |
| sd_ba | output | 2 | Bank lines |
| sd_dqm | output | 2 | Byte mask lines |

## Verification
Every pin pattern, `cmd_done`, `cmd_reject` and the clock-enable change are registered once, so each is due in the cycle that follows the accepting edge. The bench drives a request on a falling edge and compares all outputs on the next falling edge. It then checks the idle pattern one cycle later. After a self-refresh exit, `req_ready` is sampled once per cycle: it must be low for exactly `EXIT_CYC` samples and high at the following one. A request is pushed in during that window to confirm that it produces neither done nor reject.

// File: rtl/sdcs_pkg.sv
package sdcs_pkg;

   typedef enum logic [2:0] {
      CMD_ACT  = 3'd0,
      CMD_RD   = 3'd1,
      CMD_WR   = 3'd2,
      CMD_PRE  = 3'd3,
      CMD_AREF = 3'd4,
      CMD_SREF = 3'd5,
      CMD_SRX  = 3'd6,
      CMD_LMR  = 3'd7
   } sd_cmd_e;

   typedef enum logic [1:0] {
      CKE_KEEP = 2'd0,
      CKE_LOW  = 2'd1,
      CKE_HIGH = 2'd2
   } cke_op_e;

   typedef struct packed {
      logic ras_n;
      logic cas_n;
      logic we_n;
   } strobe_t;

   localparam strobe_t STB_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/sdcs_decode.sv
module sdcs_decode
   import sdcs_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int BA_W   = 2,
   parameter int DQM_W  = 2,
   parameter int DEV_N  = 2,
   parameter int AP_BIT = 10
) (
   input  logic [2:0]        cmd,
   input  logic [DEV_N-1:0]  dev,
   input  logic [BA_W-1:0]   bank,
   input  logic [ADDR_W-1:0] addr,
   input  logic              auto_pc,
   input  logic [DQM_W-1:0]  dqm,
   input  logic              init_done,
   output logic              ok,
   output logic              refuse,
   output logic              drive,
   output strobe_t           stb,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BA_W-1:0]   ba_o,
   output logic [DQM_W-1:0]  dqm_o,
   output cke_op_e           cke_op
);

   sd_cmd_e c;
   logic    is_rw;
   logic    no_dev;

   always_comb begin
      c      = sd_cmd_e'(cmd);
      is_rw  = (c == CMD_RD) || (c == CMD_WR);
      no_dev = (dev == '0);
      ok     = 1'b0;
      refuse = 1'b0;
      drive  = 1'b0;
      stb    = STB_IDLE;
      addr_o = '0;
      ba_o   = '0;
      dqm_o  = '0;
      cke_op = CKE_KEEP;
      if (no_dev || (is_rw && !init_done)) begin
         refuse = 1'b1;
      end else begin
         ok = 1'b1;
         case (c)
            CMD_ACT: begin
               drive  = 1'b1;
               stb    = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
               addr_o = addr;
               ba_o   = bank;
            end
            CMD_RD, CMD_WR: begin
               drive          = 1'b1;
               stb            = '{ras_n: 1'b1, cas_n: 1'b0, we_n: (c == CMD_RD)};
               addr_o         = addr;
               addr_o[AP_BIT] = auto_pc;
               ba_o           = bank;
               dqm_o          = dqm;
            end
            CMD_PRE: begin
               drive          = 1'b1;
               stb            = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
               addr_o[AP_BIT] = auto_pc;
               ba_o           = auto_pc ? '0 : bank;
            end
            CMD_AREF: begin
               drive = 1'b1;
               stb   = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            end
            CMD_SREF: begin
               drive  = 1'b1;
               stb    = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
               cke_op = CKE_LOW;
            end
            CMD_SRX: begin
               cke_op = CKE_HIGH;
            end
            CMD_LMR: begin
               drive  = 1'b1;
               stb    = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
               addr_o = addr;
               ba_o   = bank;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/sdcs_cke_bank.sv
module sdcs_cke_bank
   import sdcs_pkg::*;
#(
   parameter int DEV_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic [DEV_N-1:0] dev,
   input  cke_op_e          cke_op,
   output logic [DEV_N-1:0] cke_o
);

   for (genvar i = 0; i < DEV_N; i++) begin : g_dev
      logic q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= 1'b1;
         end else if (upd && dev[i]) begin
            if (cke_op == CKE_LOW) begin
               q <= 1'b0;
            end else if (cke_op == CKE_HIGH) begin
               q <= 1'b1;
            end
         end
      end

      assign cke_o[i] = q;

      // R7: self-refresh entry leaves the device with clock enable low
      a_r7_sref_low: assert property (@(posedge clk) disable iff (!rst_n)
         (upd && dev[i] && cke_op == CKE_LOW) |=> !cke_o[i]);

      // R11: exit brings clock enable back high
      a_r11_exit_high: assert property (@(posedge clk) disable iff (!rst_n)
         (upd && dev[i] && cke_op == CKE_HIGH) |=> cke_o[i]);

      // R7: unselected devices keep their clock enable
      a_r7_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
         (!(upd && dev[i])) |=> (cke_o[i] == $past(cke_o[i])));
   end

endmodule

// File: rtl/sdcs_exit_timer.sv
module sdcs_exit_timer #(
   parameter int EXIT_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic ready
);

   localparam int CNT_W = $clog2(EXIT_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(EXIT_CYC);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= CNT_LOAD;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign ready = (cnt_q == '0);

   // R11: a self-refresh exit always opens a busy window
   a_r11_busy_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !ready);

   // R11: no new exit is loaded while busy
   a_r11_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !load);

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
   import sdcs_pkg::*;
#(
   parameter int ADDR_W   = 13,
   parameter int BA_W     = 2,
   parameter int DQM_W    = 2,
   parameter int DEV_N    = 2,
   parameter int AP_BIT   = 10,
   parameter int EXIT_CYC = 4,
   parameter bit IDLE_NOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_done,
   input  logic              req_valid,
   input  logic [2:0]        req_cmd,
   input  logic [DEV_N-1:0]  req_dev,
   input  logic [BA_W-1:0]   req_bank,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_auto,
   input  logic [DQM_W-1:0]  req_dqm,
   output logic              req_ready,
   output logic              cmd_done,
   output logic              cmd_reject,
   output logic [DEV_N-1:0]  sd_cs_n,
   output logic [DEV_N-1:0]  sd_cke,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [ADDR_W-1:0] sd_addr,
   output logic [BA_W-1:0]   sd_ba,
   output logic [DQM_W-1:0]  sd_dqm
);

   if (AP_BIT >= ADDR_W) begin : g_bad_ap
      $error("AP_BIT must index an address line");
   end
   if (DEV_N < 1) begin : g_bad_dev
      $error("DEV_N must be at least 1");
   end
   if (EXIT_CYC < 1) begin : g_bad_exit
      $error("EXIT_CYC must be at least 1");
   end

   logic [DEV_N-1:0] idle_cs_n;
   if (IDLE_NOP) begin : g_idle_nop
      assign idle_cs_n = '0;
   end else begin : g_idle_dsel
      assign idle_cs_n = '1;
   end

   logic              dec_ok, dec_refuse, dec_drive;
   strobe_t           dec_stb;
   logic [ADDR_W-1:0] dec_addr;
   logic [BA_W-1:0]   dec_ba;
   logic [DQM_W-1:0]  dec_dqm;
   cke_op_e           dec_cke;
   logic              accept;

   sdcs_decode #(
      .ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W), .DEV_N(DEV_N), .AP_BIT(AP_BIT)
   ) u_decode (
      .cmd(req_cmd), .dev(req_dev), .bank(req_bank), .addr(req_addr),
      .auto_pc(req_auto), .dqm(req_dqm), .init_done(init_done),
      .ok(dec_ok), .refuse(dec_refuse), .drive(dec_drive), .stb(dec_stb),
      .addr_o(dec_addr), .ba_o(dec_ba), .dqm_o(dec_dqm), .cke_op(dec_cke)
   );

   assign accept = req_valid && req_ready;

   sdcs_cke_bank #(.DEV_N(DEV_N)) u_cke (
      .clk(clk), .rst_n(rst_n), .upd(accept && dec_ok),
      .dev(req_dev), .cke_op(dec_cke), .cke_o(sd_cke)
   );

   sdcs_exit_timer #(.EXIT_CYC(EXIT_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .load(accept && dec_ok && dec_cke == CKE_HIGH),
      .ready(req_ready)
   );

   strobe_t stb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stb_q      <= STB_IDLE;
         sd_cs_n    <= '1;
         sd_addr    <= '0;
         sd_ba      <= '0;
         sd_dqm     <= '0;
         cmd_done   <= 1'b0;
         cmd_reject <= 1'b0;
      end else begin
         cmd_done   <= accept && dec_ok;
         cmd_reject <= accept && dec_refuse;
         if (accept && dec_drive) begin
            stb_q   <= dec_stb;
            sd_cs_n <= ~req_dev;
            sd_addr <= dec_addr;
            sd_ba   <= dec_ba;
            sd_dqm  <= dec_dqm;
         end else begin
            stb_q   <= STB_IDLE;
            sd_cs_n <= idle_cs_n;
            sd_addr <= '0;
            sd_ba   <= '0;
            sd_dqm  <= '0;
         end
      end
   end

   assign sd_ras_n = stb_q.ras_n;
   assign sd_cas_n = stb_q.cas_n;
   assign sd_we_n  = stb_q.we_n;

   // R2 / R3: without a done pulse the strobes are idle
   a_r3_idle_between: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_done |-> (sd_ras_n && sd_cas_n && sd_we_n));

   // R10: read/write before initialization is refused
   a_r10_rw_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !init_done &&
       (req_cmd == CMD_RD || req_cmd == CMD_WR)) |=> (cmd_reject && !cmd_done));

   // R10: a refusal never shows a command on the pins
   a_r10_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reject |-> (sd_ras_n && sd_cas_n && sd_we_n && !cmd_done));

   // R11: while busy, requests have no effect
   a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> (!cmd_done && !cmd_reject));

   // R9: a chip select can only be low in the cycle of a command or a NOP idle
   a_r9_cs_only_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (!IDLE_NOP && !cmd_done) |-> (sd_cs_n == '1));

endmodule

// File: tb/sdram_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_seq_tb_top;

   localparam int EXIT_CYC = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        init_done;
   logic        req_valid;
   logic [2:0]  req_cmd;
   logic [1:0]  req_dev;
   logic [1:0]  req_bank;
   logic [12:0] req_addr;
   logic        req_auto;
   logic [1:0]  req_dqm;
   logic        req_ready, cmd_done, cmd_reject;
   logic [1:0]  sd_cs_n, sd_cke;
   logic        sd_ras_n, sd_cas_n, sd_we_n;
   logic [12:0] sd_addr;
   logic [1:0]  sd_ba, sd_dqm;

   int n_chk  = 0;
   int n_fail = 0;
   logic [1:0] cke_exp = 2'b11;

   always #10 clk = ~clk;

   sdram_cmd_seq #(.EXIT_CYC(EXIT_CYC)) dut_i (
      .clk(clk), .rst_n(rst_n), .init_done(init_done),
      .req_valid(req_valid), .req_cmd(req_cmd), .req_dev(req_dev),
      .req_bank(req_bank), .req_addr(req_addr), .req_auto(req_auto),
      .req_dqm(req_dqm), .req_ready(req_ready), .cmd_done(cmd_done),
      .cmd_reject(cmd_reject), .sd_cs_n(sd_cs_n), .sd_cke(sd_cke),
      .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
      .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dqm(sd_dqm)
   );

   // packed pin view: cs_n(2) ras cas we ba(2) addr(13) dqm(2)
   function automatic logic [21:0] pins_now();
      return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr, sd_dqm};
   endfunction

   localparam logic [21:0] PINS_IDLE = {2'b11, 3'b111, 2'b00, 13'd0, 2'b00};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic string req_tag(input logic [2:0] c);
      case (c)
         3'd0: return "R4";
         3'd1, 3'd2: return "R5";
         3'd3: return "R6";
         3'd4, 3'd5: return "R7";
         3'd6: return "R11";
         default: return "R8";
      endcase
   endfunction

   // expected pins, done, reject from the requirements
   task automatic expect_of(input logic [2:0] c, input logic [1:0] dv, input logic [1:0] bk,
                            input logic [12:0] ad, input logic au, input logic [1:0] dq,
                            input logic ini, output logic [21:0] pins,
                            output logic done, output logic rej);
      logic [2:0]  s;
      logic [1:0]  b;
      logic [12:0] a;
      logic [1:0]  m;
      pins = PINS_IDLE;
      done = 1'b0;
      rej  = 1'b0;
      if (dv == 2'b00 || ((c == 3'd1 || c == 3'd2) && !ini)) begin
         rej = 1'b1;
         return;
      end
      done = 1'b1;
      if (c == 3'd6) return;
      b = 2'b00; a = 13'd0; m = 2'b00;
      case (c)
         3'd0: begin s = 3'b011; a = ad; b = bk; end
         3'd1: begin s = 3'b101; a = {ad[12:11], au, ad[9:0]}; b = bk; m = dq; end
         3'd2: begin s = 3'b100; a = {ad[12:11], au, ad[9:0]}; b = bk; m = dq; end
         3'd3: begin s = 3'b010; a[10] = au; b = au ? 2'b00 : bk; end
         3'd4, 3'd5: s = 3'b001;
         default: begin s = 3'b000; a = ad; b = bk; end
      endcase
      pins = {~dv, s, b, a, m};
   endtask

   task automatic issue(input logic [2:0] c, input logic [1:0] dv, input logic [1:0] bk,
                        input logic [12:0] ad, input logic au, input logic [1:0] dq);
      logic [21:0] ep;
      logic        ed, er;
      string       t;
      while (!req_ready) @(negedge clk);
      req_cmd = c; req_dev = dv; req_bank = bk; req_addr = ad; req_auto = au; req_dqm = dq;
      req_valid = 1'b1;
      expect_of(c, dv, bk, ad, au, dq, init_done, ep, ed, er);
      @(negedge clk);
      req_valid = 1'b0;
      t = er ? "R10" : req_tag(c);
      if (ed && c == 3'd5) cke_exp = cke_exp & ~dv;
      if (ed && c == 3'd6) cke_exp = cke_exp | dv;
      chk({t, " pins"}, 32'(pins_now()), 32'(ep));
      chk({t, " R9 done"}, 32'(cmd_done), 32'(ed));
      chk({t, " reject"}, 32'(cmd_reject), 32'(er));
      chk({t, " cke"}, 32'(sd_cke), 32'(cke_exp));
      if (ed && c == 3'd6) begin
         chk("R11 busy start", 32'(req_ready), 32'd0);
         for (int k = 1; k < EXIT_CYC; k++) begin
            if (k == 1) begin
               req_cmd = 3'd0; req_dev = 2'b11; req_valid = 1'b1;
            end
            @(negedge clk);
            req_valid = 1'b0;
            chk("R11 busy", 32'(req_ready), 32'd0);
            chk("R11 ignored", 32'({cmd_done, cmd_reject, sd_ras_n}), 32'b001);
         end
         @(negedge clk);
         chk("R11 ready again", 32'(req_ready), 32'd1);
         chk("R11 no late cmd", 32'(pins_now()), 32'(PINS_IDLE));
      end else begin
         @(negedge clk);
         chk("R3 R2 idle after", 32'(pins_now()), 32'(PINS_IDLE));
         chk("R3 done drops", 32'({cmd_done, cmd_reject}), 32'd0);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h51d7));
      rst_n = 1'b0; init_done = 1'b0; req_valid = 1'b0;
      req_cmd = '0; req_dev = '0; req_bank = '0; req_addr = '0; req_auto = 1'b0; req_dqm = '0;
      repeat (3) @(negedge clk);
      chk("R1 pins in reset", 32'(pins_now()), 32'(PINS_IDLE));
      chk("R1 flags in reset", 32'({cmd_done, cmd_reject, req_ready, sd_cke}), 32'b00111);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 pins after reset", 32'(pins_now()), 32'(PINS_IDLE));
      chk("R1 R2 flags after reset", 32'({cmd_done, cmd_reject, req_ready, sd_cke}), 32'b00111);

      // directed corner cases
      issue(3'd2, 2'b01, 2'd1, 13'h0123, 1'b0, 2'b10);   // R10 write before init
      issue(3'd1, 2'b11, 2'd2, 13'h0042, 1'b1, 2'b01);   // R10 read before init
      issue(3'd7, 2'b11, 2'd0, 13'h0233, 1'b0, 2'b00);   // R8 R9 broadcast mode load
      issue(3'd0, 2'b10, 2'd3, 13'h1fff, 1'b0, 2'b00);   // R4 device 1 only
      init_done = 1'b1;
      issue(3'd1, 2'b01, 2'd2, 13'h1bff, 1'b0, 2'b11);   // R5 read, bit 10 cleared
      issue(3'd2, 2'b10, 2'd1, 13'h0011, 1'b1, 2'b01);   // R5 write with auto precharge
      issue(3'd3, 2'b11, 2'd3, 13'h1fff, 1'b1, 2'b00);   // R6 all banks
      issue(3'd3, 2'b01, 2'd2, 13'h1fff, 1'b0, 2'b00);   // R6 one bank
      issue(3'd4, 2'b11, 2'd0, 13'h0000, 1'b0, 2'b00);   // R7 auto-refresh
      issue(3'd5, 2'b01, 2'd0, 13'h0000, 1'b0, 2'b00);   // R7 self-refresh dev0
      issue(3'd6, 2'b01, 2'd0, 13'h0000, 1'b0, 2'b00);   // R11 exit
      issue(3'd0, 2'b00, 2'd1, 13'h0100, 1'b0, 2'b00);   // R10 empty mask
      issue(3'd5, 2'b11, 2'd0, 13'h0000, 1'b0, 2'b00);   // R7 both devices
      issue(3'd6, 2'b11, 2'd0, 13'h0000, 1'b0, 2'b00);   // R11 both

      for (int i = 0; i < 300; i++) begin
         init_done = ($urandom_range(0, 7) != 0);
         issue(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
               13'($urandom_range(0, 8191)), 1'($urandom_range(0, 1)),
               2'($urandom_range(0, 3)));
      end

      summary();
      $finish;
   end

endmodule